// File: doc/BRIEF.md
# Stereo Attenuation Gain Combiner

This block takes two cascaded 16-bit volume words, a master stage and a PCM-output stage, and turns them into one pair of 8-bit linear gains (left and right) plus a single mute flag. Each word carries a 5-bit attenuation code per channel. Each code becomes a stage gain. The two stage gains of a channel are multiplied and the product is renormalised by an exact integer divide by 255. The mute flag is the OR of the two stages' mute bits.

A one-cycle `load` strobe captures both words and starts a sequential computation. The control state machine moves through `IDLE`, `MUL`, `PREP` and `DIV`. Its transitions are: `IDLE->MUL` on load, `MUL->PREP` after eight shift-add steps, `PREP->DIV` after one cycle, and `DIV->IDLE` after eight restoring-divide steps. On that last transition the new outputs are written and `done` pulses for one cycle. Both channels run in lock-step in two identical lanes. Between updates the outputs hold their value.

Top module: `gain_combiner`

## Requirements
- R1: While reset is held and after its release, `mute_o` is 1, `gain_l_o` and `gain_r_o` are 255, and `done_o` is 0.
- R2: In each volume word the left code is bits 12:8 and the right code is bits 4:0. Bits 14:13 and 7:5 have no effect on the gains.
- R3: A code v gives the stage gain 255 - floor(255*v/31). Code 0 therefore gives a stage gain of 255 and code 31 gives 0.
- R4: Each channel's output gain is floor(Gmaster*Gpcm/255), with the exact integer result for all 32x32 code pairs.
- R5: `mute_o` equals bit 15 of the master word ORed with bit 15 of the PCM word. Bit 15 has no effect on the gains.
- R6: Outputs and `done_o` change on the 17th rising edge after the edge that samples `load_i` high, and `done_o` is high for exactly one cycle.
- R7: Between updates the outputs hold their value. A change on the volume inputs after the load edge does not change the result.
- R8: A `load_i` pulse that arrives while a computation is running is ignored and does not start a second update.
- R9: The left and right results are computed independently, each from its own pair of codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start strobe; captures both volume words |
| master_vol_i | input | 16 | Master stage volume word |
| pcm_vol_i | input | 16 | PCM-output stage volume word |
| gain_l_o | output | 8 | Combined left gain |
| gain_r_o | output | 8 | Combined right gain |
| mute_o | output | 1 | Combined mute flag |
| done_o | output | 1 | One-cycle pulse when new outputs are valid |

## Verification
All results are due on a single edge: the gains, the mute flag and `done_o` all change on the 17th rising edge after the load edge. The bench drives inputs on falling edges. It counts sixteen falling edges after the load edge and checks that `done_o` is still low and the old values still hold. It then checks the new values and the `done` pulse on the next falling edge, and checks one cycle later that `done_o` has dropped. The same fixed offset applies to the exhaustive sweep over all code pairs, to the reloads issued during a computation, and to the input changes made right after a load.

// File: rtl/gain_comb_pkg.sv
package gain_comb_pkg;

    localparam int CODE_W     = 5;
    localparam int GAIN_W     = 8;
    localparam int PROD_W     = 2 * GAIN_W;
    localparam int FULL_SCALE = (1 << GAIN_W) - 1;
    localparam int CODE_MAX   = (1 << CODE_W) - 1;
    localparam int SCL_W      = GAIN_W + CODE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_PREP,
        ST_DIV
    } gc_state_e;

    // Stage gain: full scale minus the code scaled onto the full-scale range.
    function automatic logic [GAIN_W-1:0] stage_gain(input logic [CODE_W-1:0] code);
        logic [SCL_W-1:0] scaled;
        logic [SCL_W-1:0] ratio;
        scaled = SCL_W'(code) * SCL_W'(FULL_SCALE);
        ratio  = scaled / SCL_W'(CODE_MAX);
        return GAIN_W'(SCL_W'(FULL_SCALE) - ratio);
    endfunction

endpackage

// File: rtl/gain_comb_ctrl.sv
module gain_comb_ctrl
    import gain_comb_pkg::*;
#(
    parameter int STEPS = GAIN_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic start_o,
    output logic mul_en_o,
    output logic prep_o,
    output logic div_en_o,
    output logic commit_o,
    output logic done_o
);

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    gc_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (load_i) state_d = ST_MUL;
            end
            ST_MUL: begin
                if (cnt_q == LAST) begin
                    state_d = ST_PREP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PREP: begin
                state_d = ST_DIV;
                cnt_d   = '0;
            end
            ST_DIV: begin
                if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start_o  = 1'b0;
        mul_en_o = 1'b0;
        prep_o   = 1'b0;
        div_en_o = 1'b0;
        commit_o = 1'b0;
        unique case (state_q)
            ST_IDLE: start_o  = load_i;
            ST_MUL:  mul_en_o = 1'b1;
            ST_PREP: prep_o   = 1'b1;
            ST_DIV: begin
                div_en_o = 1'b1;
                commit_o = (cnt_q == LAST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= commit_o;
    end
    assign done_o = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
    AST_DIV_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV && cnt_q == LAST) |=> (state_q == ST_IDLE && done_q)); // R6
    AST_MUL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL && load_i) |=> (state_q == ST_MUL || state_q == ST_PREP)); // R8

endmodule

// File: rtl/gain_comb_lane.sv
module gain_comb_lane
    import gain_comb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mul_en_i,
    input  logic              prep_i,
    input  logic              div_en_i,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] code_a_i,
    input  logic [CODE_W-1:0] code_b_i,
    output logic [GAIN_W-1:0] gain_o
);

    localparam logic [GAIN_W:0] DIVISOR = (GAIN_W+1)'(FULL_SCALE);

    logic [PROD_W-1:0] mcand_q, acc_q;
    logic [GAIN_W-1:0] mplier_q, rem_q, low_q, quo_q, gain_q;
    logic [GAIN_W:0]   trial;
    logic              fits;

    assign trial = {rem_q, low_q[GAIN_W-1]};
    assign fits  = (trial >= DIVISOR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            rem_q    <= '0;
            low_q    <= '0;
            quo_q    <= '0;
            gain_q   <= GAIN_W'(FULL_SCALE);
        end else begin
            if (start_i) begin
                mcand_q  <= PROD_W'(stage_gain(code_a_i));
                mplier_q <= stage_gain(code_b_i);
                acc_q    <= '0;
            end
            if (mul_en_i) begin
                if (mplier_q[0]) acc_q <= acc_q + mcand_q;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
            end
            if (prep_i) begin
                rem_q <= acc_q[PROD_W-1:GAIN_W];
                low_q <= acc_q[GAIN_W-1:0];
                quo_q <= '0;
            end
            if (div_en_i) begin
                rem_q <= fits ? GAIN_W'(trial - DIVISOR) : trial[GAIN_W-1:0];
                low_q <= low_q << 1;
                quo_q <= {quo_q[GAIN_W-2:0], fits};
            end
            if (commit_i) begin
                gain_q <= {quo_q[GAIN_W-2:0], fits};
            end
        end
    end

    assign gain_o = gain_q;

    AST_PROD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        prep_i |-> (acc_q[PROD_W-1:GAIN_W] < GAIN_W'(FULL_SCALE))); // R4
    AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_en_i |-> (rem_q < GAIN_W'(FULL_SCALE))); // R4

endmodule

// File: rtl/gain_combiner.sv
module gain_combiner
    import gain_comb_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int LEFT_LSB  = 8,
    parameter int RIGHT_LSB = 0,
    parameter int MUTE_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [REG_W-1:0]  master_vol_i,
    input  logic [REG_W-1:0]  pcm_vol_i,
    output logic [GAIN_W-1:0] gain_l_o,
    output logic [GAIN_W-1:0] gain_r_o,
    output logic              mute_o,
    output logic              done_o
);

    localparam int NCH = 2;

    logic start, mul_en, prep, div_en, commit;
    logic mute_pend_q, mute_q;
    logic [GAIN_W-1:0] gain_w [NCH];
    logic unused_vol_bits;

    assign unused_vol_bits = ^{master_vol_i, pcm_vol_i};

    gain_comb_ctrl #(.STEPS(GAIN_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .start_o  (start),
        .mul_en_o (mul_en),
        .prep_o   (prep),
        .div_en_o (div_en),
        .commit_o (commit),
        .done_o   (done_o)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        localparam int LSB = (ch == 0) ? LEFT_LSB : RIGHT_LSB;
        gain_comb_lane lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start),
            .mul_en_i (mul_en),
            .prep_i   (prep),
            .div_en_i (div_en),
            .commit_i (commit),
            .code_a_i (master_vol_i[LSB +: CODE_W]),
            .code_b_i (pcm_vol_i[LSB +: CODE_W]),
            .gain_o   (gain_w[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_pend_q <= 1'b1;
            mute_q      <= 1'b1;
        end else begin
            if (start)  mute_pend_q <= master_vol_i[MUTE_BIT] | pcm_vol_i[MUTE_BIT];
            if (commit) mute_q      <= mute_pend_q;
        end
    end

    assign gain_l_o = gain_w[0];
    assign gain_r_o = gain_w[1];
    assign mute_o   = mute_q;

    AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(gain_l_o)); // R7
    AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(gain_r_o)); // R7
    AST_HOLD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(mute_o)); // R5

endmodule

// File: tb/gain_combiner_tb_top.sv
`timescale 1ns/1ps
module gain_combiner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] master_vol_i = '0;
    logic [15:0] pcm_vol_i = '0;
    logic [7:0]  gain_l_o, gain_r_o;
    logic        mute_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gain_combiner dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .master_vol_i (master_vol_i),
        .pcm_vol_i    (pcm_vol_i),
        .gain_l_o     (gain_l_o),
        .gain_r_o     (gain_r_o),
        .mute_o       (mute_o),
        .done_o       (done_o)
    );

    function automatic int sg(input int v);
        return 255 - (255 * v) / 31;
    endfunction

    function automatic int comb(input int a, input int b);
        return (sg(a) * sg(b)) / 255;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one load; optionally disturb inputs after the load edge or pulse
    // load again mid-run. Checks timing, values and the done pulse.
    task automatic run(input logic [15:0] m, input logic [15:0] p,
                       input int el, input int er, input int em,
                       input bit disturb, input bit reload, input string req);
        int old_l, old_r, old_m;
        old_l = gain_l_o; old_r = gain_r_o; old_m = mute_o;
        @(negedge clk);
        master_vol_i = m; pcm_vol_i = p; load_i = 1'b1;
        @(negedge clk);                       // load edge passed
        load_i = 1'b0;
        if (disturb) begin
            master_vol_i = ~m; pcm_vol_i = ~p;
        end
        for (int k = 1; k <= 16; k++) begin
            if (reload && k == 5) begin
                master_vol_i = 16'h1F1F; pcm_vol_i = 16'h0000; load_i = 1'b1;
            end else begin
                load_i = 1'b0;
            end
            @(negedge clk);
        end
        load_i = 1'b0;
        check({req, " done low before edge 17"}, done_o, 0);
        check({req, " R7 left held"}, gain_l_o, old_l);
        check({req, " R7 right held"}, gain_r_o, old_r);
        check({req, " R7 mute held"}, mute_o, old_m);
        @(negedge clk);
        check({req, " R6 done at edge 17"}, done_o, 1);
        check({req, " left"}, gain_l_o, el);
        check({req, " right"}, gain_r_o, er);
        check({req, " mute"}, mute_o, em);
        @(negedge clk);
        check({req, " R6 done one cycle"}, done_o, 0);
    endtask

    task automatic t_reset();
        check("R1 mute at reset", mute_o, 1);
        check("R1 left at reset", gain_l_o, 255);
        check("R1 right at reset", gain_r_o, 255);
        check("R1 done at reset", done_o, 0);
        repeat (3) @(negedge clk);
        check("R1 left idle", gain_l_o, 255);
        check("R1 done idle", done_o, 0);
    endtask

    task automatic t_stage();
        // R3: master codes with PCM code 0 (stage gain 255) pass the stage gain through
        run(16'h0000, 16'h0000, 255, 255, 0, 0, 0, "R3 codes 0/0");
        run(16'h1F1F, 16'h0000, 0, 0, 0, 0, 0, "R3 code 31");
        run(16'h0100, 16'h0000, 247, 255, 0, 0, 0, "R3 code 1");
        run(16'h1000, 16'h0010, sg(16), sg(16), 0, 0, 0, "R3 code 16");
    endtask

    task automatic t_fields();
        // R2: bits 14:13 and 7:5 set, must not change gains
        run(16'h60E5, 16'h60E0, comb(0, 0), comb(5, 0), 0, 0, 0, "R2 ignored bits");
        // R9: independent channels
        run(16'h0A03, 16'h1407, comb(10, 20), comb(3, 7), 0, 0, 0, "R9 mixed");
    endtask

    task automatic t_mute();
        run(16'h8000, 16'h0000, 255, 255, 1, 0, 0, "R5 master mute");
        run(16'h0000, 16'h8000, 255, 255, 1, 0, 0, "R5 pcm mute");
        run(16'h8505, 16'h8202, comb(5, 2), comb(5, 2), 1, 0, 0, "R5 both mute");
        run(16'h0505, 16'h0202, comb(5, 2), comb(5, 2), 0, 0, 0, "R5 unmute");
    endtask

    task automatic t_capture();
        run(16'h0C11, 16'h0306, comb(12, 3), comb(17, 6), 0, 1, 0, "R7 input change");
        run(16'h0408, 16'h0902, comb(4, 9), comb(8, 2), 0, 0, 1, "R8 reload busy");
        // no second update after the ignored reload
        repeat (20) @(negedge clk) check("R8 no extra done", done_o, 0);
        check("R8 left unchanged", gain_l_o, comb(4, 9));
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                run(16'((a << 8) | (31 - a)), 16'((b << 8) | (31 - b)),
                    comb(a, b), comb(31 - a, 31 - b), 0, 0, 0, "R4 sweep");
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage();
        t_fields();
        t_mute();
        t_capture();
        t_sweep();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule